// File: doc/BRIEF.md
# Frame-Synchronized Step Pulse Burst Generator

This block produces one burst of step pulses for a single motor channel in every period of a frame sync input. A rising edge on the sync input opens the frame and starts a start-up wait. When that wait expires, a second wait, the drive wait, follows. When the drive wait expires, the block emits four times a programmed 6-bit count of step pulses, each a programmed number of clocks long. Both waits are measured in units of `UNIT_CLKS` clocks. A unit is 256 us at the default 1024 clocks of a 4 MHz clock. The block exports the start-up wait flag and the combined wait flag (high across both waits) as status outputs.

Parameters come from a serial decoder upstream as staged values, and each takes effect at a fixed point in the frame. The two wait lengths are captured at the sync rising edge. Period, count and direction move to the working registers when the combined flag falls. Enable and current-select also move there, except when enable changes from 0 to 1: then they move one wait earlier, when the start-up flag falls. A burst is suppressed, and the pulse-present flag stays low, in these cases: a zero count, a bad checksum, a frame whose staged data strobe did not arrive before the start-up wait ended, a frame begun by a sync edge that interrupted the waits, or a missing sync.

The controller is a five-state machine. `ST_IDLE` is the state after reset or after the sync is lost. `ST_STARTUP` times the start-up wait. `ST_DRIVE` times the drive wait. `ST_BURST` emits pulses. `ST_DONE` holds until the next sync. Transitions are as follows. Any state goes to `ST_STARTUP` on a sync rising edge. Any other state goes to `ST_IDLE` on sync timeout. `ST_STARTUP` goes to `ST_DRIVE` when its wait expires. `ST_DRIVE` goes to `ST_BURST` when its wait expires and the burst is allowed, and to `ST_DONE` when it is not. `ST_BURST` goes to `ST_DONE` after the last pulse period.

Top module: `frame_step_burst`

## Requirements
- R1: `wait_start_out` rises one clock after the clock edge at which `sync_in` is first seen high. It stays high for exactly `cfg_wait_start` x `UNIT_CLKS` clocks. A value of 0 acts as 1.
- R2: `wait_all_out` is high during the start-up wait and the following drive wait. The drive wait lasts `cfg_wait_drive` x `UNIT_CLKS` clocks, using the value captured at the sync edge. A value of 0 acts as 1.
- R3: When allowed, the burst starts on the clock where `wait_all_out` falls. It holds 4 x `cfg_count` pulses of P clocks each, where P = `cfg_period` and values below 2 act as 2. `gate_out` is high for exactly 4 x count x P clocks, and `step_out` is high only while `gate_out` is high.
- R4: Each step pulse is high for floor(P/2) clocks, then low for the rest of its period.
- R5: Count, period and `dir_out` take the staged values only on the clock where `wait_all_out` falls.
- R6: `enable_out` and `cur_sel_out` take the staged values where `wait_all_out` falls. The exception is a staged enable of 1 while `enable_out` is 0: in that case they take the staged values where `wait_start_out` falls.
- R7: A zero count or a low `chk_ok` at the fall of `wait_all_out` gives no pulses and leaves `present_out` low. Otherwise `present_out` goes high at that clock.
- R8: If no `load_stb` pulse arrives between the sync edge and the end of the start-up wait, that frame gives no pulses and `present_out` stays low.
- R9: A frame whose sync edge arrives while either wait is still running gives no pulses and `present_out` stays low. The following normally started frame bursts again.
- R10: If no sync rising edge is seen for `SYNC_TMO` clocks, the block returns to idle. All flags, `gate_out` and `present_out` go low. The next sync edge starts a normal frame.
- R11: A sync edge during a burst cuts the burst off. Only the pulses already started are emitted, and a new start-up wait begins.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (4 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Frame sync, synchronous to clk |
| load_stb | input | 1 | One-clock strobe: staged data for this frame is complete |
| cfg_wait_start | input | WAIT_W | Start-up wait length in units |
| cfg_wait_drive | input | WAIT_W | Drive wait length in units |
| cfg_enable | input | 1 | Staged output enable |
| cfg_dir | input | 1 | Staged rotation direction |
| cfg_cur_sel | input | 1 | Staged current-setting select |
| cfg_count | input | CNT_W | Staged pulse count in groups of four |
| cfg_period | input | PER_W | Staged pulse period in clocks |
| chk_ok | input | 1 | Checksum of the staged data is good |
| step_out | output | 1 | Step pulse |
| gate_out | output | 1 | High while a burst runs |
| present_out | output | 1 | Burst of this frame is allowed |
| wait_start_out | output | 1 | Start-up wait flag |
| wait_all_out | output | 1 | Combined wait flag |
| enable_out | output | 1 | Working enable |
| dir_out | output | 1 | Working direction |
| cur_sel_out | output | 1 | Working current select |

## Verification
The bench targets the points where a wrong design would still look busy. A wait off by one unit would shift the burst. A 0-to-1 enable that waits for the later flag edge would leave `enable_out` low through the drive wait. A direction that follows the staged input at once would change mid-frame. A wait overrun that is not remembered would let the next frame burst. It also covers truncation by an early sync, which must stop at exactly the pulses already begun, and sync loss, which must clear the present flag. Periods of 0, 1 and odd values, and a start-up wait of 0, check the clamping and the floor of the pulse width.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STARTUP,
        ST_DRIVE,
        ST_BURST,
        ST_DONE
    } fsb_state_t;
endpackage

// File: rtl/fsb_sync_watch.sv
module fsb_sync_watch #(
    parameter int SYNC_TMO = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise,
    output logic tmo_evt
);
    localparam int TMO_W = (SYNC_TMO > 2) ? $clog2(SYNC_TMO) : 1;

    logic             sync_q;
    logic             lost_q;
    logic [TMO_W-1:0] age_q;

    assign rise    = sync_in && !sync_q;
    assign tmo_evt = !rise && !lost_q && (age_q == TMO_W'(SYNC_TMO - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            lost_q <= 1'b1;
            age_q  <= '0;
        end else begin
            sync_q <= sync_in;
            if (rise) begin
                lost_q <= 1'b0;
                age_q  <= '0;
            end else if (tmo_evt) begin
                lost_q <= 1'b1;
            end else if (!lost_q) begin
                age_q <= age_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsb_wait_timer.sv
module fsb_wait_timer #(
    parameter int UNIT_CLKS = 1024,
    parameter int WAIT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [WAIT_W-1:0] units,
    output logic              done
);
    localparam int UNIT_W = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;

    logic              active_q;
    logic [UNIT_W-1:0] tick_q;
    logic [WAIT_W-1:0] left_q;
    logic              unit_end;
    logic [WAIT_W-1:0] units_eff;

    assign unit_end  = (tick_q == UNIT_W'(UNIT_CLKS - 1));
    assign units_eff = (units == '0) ? WAIT_W'(1) : units;
    assign done      = active_q && unit_end && (left_q == WAIT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            tick_q   <= '0;
            left_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            tick_q   <= '0;
            left_q   <= units_eff;
        end else if (abort) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (unit_end) begin
                tick_q <= '0;
                if (left_q == WAIT_W'(1)) begin
                    active_q <= 1'b0;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsb_pulse_engine.sv
module fsb_pulse_engine #(
    parameter int PER_W = 15,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] count,
    output logic             step,
    output logic             busy,
    output logic             last
);
    localparam int PULSE_W = CNT_W + 2;

    logic [PER_W-1:0]   per_q;
    logic [PER_W-1:0]   phase_q;
    logic [PULSE_W-1:0] rem_q;
    logic               busy_q;
    logic               per_end;

    assign per_end = (phase_q == per_q - 1'b1);
    assign busy    = busy_q;
    assign last    = busy_q && per_end && (rem_q == PULSE_W'(1));
    assign step    = busy_q && (phase_q < (per_q >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q   <= PER_W'(2);
            phase_q <= '0;
            rem_q   <= '0;
            busy_q  <= 1'b0;
        end else if (start) begin
            per_q   <= (period < PER_W'(2)) ? PER_W'(2) : period;
            phase_q <= '0;
            rem_q   <= {count, 2'b00};
            busy_q  <= (count != '0);
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (per_end) begin
                phase_q <= '0;
                rem_q   <= rem_q - 1'b1;
                if (rem_q == PULSE_W'(1)) begin
                    busy_q <= 1'b0;
                end
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_step_burst.sv
module frame_step_burst #(
    parameter int UNIT_CLKS = 1024,
    parameter int SYNC_TMO  = 400000,
    parameter int WAIT_W    = 8,
    parameter int CNT_W     = 6,
    parameter int PER_W     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              load_stb,
    input  logic [WAIT_W-1:0] cfg_wait_start,
    input  logic [WAIT_W-1:0] cfg_wait_drive,
    input  logic              cfg_enable,
    input  logic              cfg_dir,
    input  logic              cfg_cur_sel,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              chk_ok,
    output logic              step_out,
    output logic              gate_out,
    output logic              present_out,
    output logic              wait_start_out,
    output logic              wait_all_out,
    output logic              enable_out,
    output logic              dir_out,
    output logic              cur_sel_out
);
    import fsb_pkg::*;

    fsb_state_t        state_q, state_d;
    logic              sync_rise, tmo_evt;
    logic              t_done, t_start;
    logic [WAIT_W-1:0] t_units;
    logic              eng_start, eng_abort, eng_step, eng_busy, eng_last;
    logic              startup_end, drive_end, allowed;
    logic              en_early;

    logic [WAIT_W-1:0] drive_units_q;
    logic              stb_seen_q, latch_ok_q, overrun_q, present_q;
    logic              en_q, dir_q, cur_q;

    fsb_sync_watch #(.SYNC_TMO(SYNC_TMO)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .rise    (sync_rise),
        .tmo_evt (tmo_evt)
    );

    fsb_wait_timer #(.UNIT_CLKS(UNIT_CLKS), .WAIT_W(WAIT_W)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .abort (tmo_evt),
        .units (t_units),
        .done  (t_done)
    );

    fsb_pulse_engine #(.PER_W(PER_W), .CNT_W(CNT_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .abort  (eng_abort),
        .period (cfg_period),
        .count  (cfg_count),
        .step   (eng_step),
        .busy   (eng_busy),
        .last   (eng_last)
    );

    // frame events, already qualified against restart and timeout
    assign startup_end = (state_q == ST_STARTUP) && t_done && !sync_rise && !tmo_evt;
    assign drive_end   = (state_q == ST_DRIVE)   && t_done && !sync_rise && !tmo_evt;
    assign allowed     = (cfg_count != '0) && chk_ok && latch_ok_q && !overrun_q;
    assign en_early    = cfg_enable && !en_q;

    assign t_start   = sync_rise || startup_end;
    assign t_units   = sync_rise ? cfg_wait_start : drive_units_q;
    assign eng_start = drive_end && allowed;
    assign eng_abort = sync_rise || tmo_evt;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (sync_rise) begin
            state_d = ST_STARTUP;
        end else if (tmo_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_STARTUP: if (t_done) state_d = ST_DRIVE;
                ST_DRIVE:   if (t_done) state_d = allowed ? ST_BURST : ST_DONE;
                ST_BURST:   if (eng_last) state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame bookkeeping and working parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_units_q <= '0;
            stb_seen_q    <= 1'b0;
            latch_ok_q    <= 1'b0;
            overrun_q     <= 1'b0;
            present_q     <= 1'b0;
            en_q          <= 1'b0;
            dir_q         <= 1'b0;
            cur_q         <= 1'b0;
        end else begin
            if (sync_rise) begin
                drive_units_q <= cfg_wait_drive;
                overrun_q     <= (state_q == ST_STARTUP) || (state_q == ST_DRIVE);
                stb_seen_q    <= load_stb;
            end else if (load_stb) begin
                stb_seen_q <= 1'b1;
            end

            if (startup_end) begin
                latch_ok_q <= stb_seen_q || load_stb;
                if (en_early) begin
                    en_q  <= 1'b1;
                    cur_q <= cfg_cur_sel;
                end
            end

            if (drive_end) begin
                dir_q <= cfg_dir;
                if (!en_early) begin
                    en_q  <= cfg_enable;
                    cur_q <= cfg_cur_sel;
                end
            end

            if (sync_rise || tmo_evt) begin
                present_q <= 1'b0;
            end else if (drive_end) begin
                present_q <= allowed;
            end
        end
    end

    // outputs
    always_comb begin
        wait_start_out = (state_q == ST_STARTUP);
        wait_all_out   = (state_q == ST_STARTUP) || (state_q == ST_DRIVE);
        gate_out       = (state_q == ST_BURST) && eng_busy;
        step_out       = (state_q == ST_BURST) && eng_step;
        present_out    = present_q;
        enable_out     = en_q;
        dir_out        = dir_q;
        cur_sel_out    = cur_q;
    end
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker (
    input logic clk,
    input logic rst_n,
    input logic sync_in,
    input logic step_out,
    input logic gate_out,
    input logic present_out,
    input logic wait_start_out,
    input logic wait_all_out,
    input logic dir_out
);
    // R2
    flags_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_start_out |-> wait_all_out);

    // R3
    step_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> gate_out);

    // R3
    gate_after_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out |-> !wait_all_out);

    // R3
    burst_at_wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> $fell(wait_all_out));

    // R11
    sync_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_in) |=> wait_start_out);

    // R7
    present_at_wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present_out) |-> $fell(wait_all_out));

    // R5
    dir_update_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_out) |-> $fell(wait_all_out));
endmodule

bind frame_step_burst fsb_checker u_fsb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_in        (sync_in),
    .step_out       (step_out),
    .gate_out       (gate_out),
    .present_out    (present_out),
    .wait_start_out (wait_start_out),
    .wait_all_out   (wait_all_out),
    .dir_out        (dir_out)
);

// File: tb/frame_step_burst_test.sv
module frame_step_burst_test;
    localparam int UNIT = 16;
    localparam int TMO  = 1000;
    localparam int FLEN = 400;
    localparam int NV   = 9;

    // w1, w2, count, period, chk, stb | pulses, gate, high, ff1, ff2, present
    localparam int VEC [0:NV-1][0:11] = '{
        '{1, 1, 1,  4, 1, 1,   4,  16,  8, 16,  32, 1},
        '{2, 3, 2,  5, 1, 1,   8,  40, 16, 32,  80, 1},
        '{3, 1, 3, 10, 1, 1,  12, 120, 60, 48,  64, 1},
        '{1, 2, 0,  4, 1, 1,   0,   0,  0, 16,  48, 0},
        '{1, 1, 2,  6, 0, 1,   0,   0,  0, 16,  32, 0},
        '{2, 2, 1,  7, 1, 0,   0,   0,  0, 32,  64, 0},
        '{0, 1, 1,  0, 1, 1,   4,   8,  4, 16,  32, 1},
        '{4, 4, 3,  3, 1, 1,  12,  36, 12, 64, 128, 1},
        '{1, 1, 1,  1, 1, 1,   4,   8,  4, 16,  32, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       load_stb = 1'b0;
    logic [7:0] cfg_wait_start = 8'd1;
    logic [7:0] cfg_wait_drive = 8'd1;
    logic       cfg_enable = 1'b0;
    logic       cfg_dir = 1'b0;
    logic       cfg_cur_sel = 1'b0;
    logic [5:0] cfg_count = 6'd1;
    logic [14:0] cfg_period = 15'd4;
    logic       chk_ok = 1'b1;
    logic       step_out, gate_out, present_out, wait_start_out, wait_all_out;
    logic       enable_out, dir_out, cur_sel_out;

    int n_checks = 0;
    int n_errors = 0;
    int frame_id = 0;
    bit finished = 1'b0;

    frame_step_burst #(.UNIT_CLKS(UNIT), .SYNC_TMO(TMO)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_in        (sync_in),
        .load_stb       (load_stb),
        .cfg_wait_start (cfg_wait_start),
        .cfg_wait_drive (cfg_wait_drive),
        .cfg_enable     (cfg_enable),
        .cfg_dir        (cfg_dir),
        .cfg_cur_sel    (cfg_cur_sel),
        .cfg_count      (cfg_count),
        .cfg_period     (cfg_period),
        .chk_ok         (chk_ok),
        .step_out       (step_out),
        .gate_out       (gate_out),
        .present_out    (present_out),
        .wait_start_out (wait_start_out),
        .wait_all_out   (wait_all_out),
        .enable_out     (enable_out),
        .dir_out        (dir_out),
        .cur_sel_out    (cur_sel_out)
    );

    always #10 clk = ~clk;

    // monitor: samples mid-cycle, counters cleared when a new frame starts
    int  seen_id = 0;
    int  n_rise, n_gate, n_high, n_ff1, n_ff2;
    bit  prev_step = 1'b0;
    bit  w2_en, w2_cur, w2_dir;
    always @(posedge clk) begin
        #5;
        if (seen_id != frame_id) begin
            seen_id = frame_id;
            n_rise = 0; n_gate = 0; n_high = 0; n_ff1 = 0; n_ff2 = 0;
        end
        if (step_out && !prev_step) n_rise++;
        if (step_out) n_high++;
        if (gate_out) n_gate++;
        if (wait_start_out) n_ff1++;
        if (wait_all_out) n_ff2++;
        if (wait_all_out && !wait_start_out) begin
            w2_en = enable_out; w2_cur = cur_sel_out; w2_dir = dir_out;
        end
        prev_step = step_out;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic frame(input int len, input bit stb);
        @(negedge clk);
        frame_id++;
        sync_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (stb) load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        @(negedge clk);
        sync_in = 1'b0;
        repeat (len - 5) @(negedge clk);
    endtask

    task automatic stage(input int w1, input int w2, input int c, input int p, input bit ok);
        cfg_wait_start = 8'(w1);
        cfg_wait_drive = 8'(w2);
        cfg_count      = 6'(c);
        cfg_period     = 15'(p);
        chk_ok         = ok;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12", "outputs after reset",
              int'({step_out, gate_out, present_out, wait_start_out, wait_all_out,
                    enable_out, dir_out, cur_sel_out}), 0);

        // table of frames: R1 R2 R3 R4 R7 R8
        for (int i = 0; i < NV; i++) begin
            stage(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4] != 0);
            frame(FLEN, VEC[i][5] != 0);
            check("R3", $sformatf("v%0d pulses", i), n_rise, VEC[i][6]);
            check("R3", $sformatf("v%0d gate clocks", i), n_gate, VEC[i][7]);
            check("R4", $sformatf("v%0d step high clocks", i), n_high, VEC[i][8]);
            check("R1", $sformatf("v%0d start-up flag clocks", i), n_ff1, VEC[i][9]);
            check("R2", $sformatf("v%0d wait flag clocks", i), n_ff2, VEC[i][10]);
            check("R7", $sformatf("v%0d present", i), int'(present_out), VEC[i][11]);
        end

        // R6 / R5: enable 0->1 takes effect at start-up wait end
        stage(2, 2, 1, 4, 1'b1);
        cfg_enable = 1'b1; cfg_cur_sel = 1'b1; cfg_dir = 1'b1;
        frame(FLEN, 1'b1);
        check("R6", "enable during drive wait after 0->1", int'(w2_en), 1);
        check("R6", "current select during drive wait after 0->1", int'(w2_cur), 1);
        check("R5", "direction held during drive wait", int'(w2_dir), 0);
        check("R5", "direction after wait end", int'(dir_out), 1);

        // R6: enable stays 1, current select moves at the later point
        cfg_cur_sel = 1'b0; cfg_dir = 1'b0;
        frame(FLEN, 1'b1);
        check("R6", "current select held during drive wait", int'(w2_cur), 1);
        check("R6", "current select after wait end", int'(cur_sel_out), 0);
        check("R5", "direction held during drive wait 2", int'(w2_dir), 1);
        check("R5", "direction after wait end 2", int'(dir_out), 0);

        // R6: enable 1->0 waits for the combined flag
        cfg_enable = 1'b0; cfg_cur_sel = 1'b1;
        frame(FLEN, 1'b1);
        check("R6", "enable held during drive wait on 1->0", int'(w2_en), 1);
        check("R6", "enable after wait end on 1->0", int'(enable_out), 0);
        check("R6", "current select after wait end on 1->0", int'(cur_sel_out), 1);

        // R11: truncation by an early sync
        stage(1, 1, 3, 20, 1'b1);
        frame(150, 1'b1);
        check("R11", "pulses before early sync", n_rise, 6);
        stage(1, 1, 1, 4, 1'b1);
        frame(FLEN, 1'b1);
        check("R11", "restarted start-up flag clocks", n_ff1, 16);
        check("R11", "pulses in frame after truncation", n_rise, 4);

        // R9: sync edge during the waits
        stage(20, 10, 1, 4, 1'b1);
        frame(FLEN, 1'b1);
        check("R9", "no pulses in overlong frame", n_rise, 0);
        check("R1", "long start-up flag clocks", n_ff1, 320);
        stage(1, 1, 1, 4, 1'b1);
        frame(FLEN, 1'b1);
        check("R9", "pulses in frame begun during waits", n_rise, 0);
        check("R9", "present in frame begun during waits", int'(present_out), 0);
        frame(FLEN, 1'b1);
        check("R9", "pulses after recovery", n_rise, 4);
        check("R9", "present after recovery", int'(present_out), 1);

        // R10: sync absent
        @(negedge clk);
        frame_id++;
        repeat (TMO + 200) @(negedge clk);
        check("R10", "pulses without sync", n_rise, 0);
        check("R10", "present without sync", int'(present_out), 0);
        check("R10", "flags without sync", int'({wait_all_out, gate_out}), 0);
        frame(FLEN, 1'b1);
        check("R10", "pulses after sync returns", n_rise, 4);
        check("R10", "present after sync returns", int'(present_out), 1);

        finish_run();
    end
endmodule